// File: doc/BRIEF.md
# Vector Loop Issue Sequencer

This stage sits between instruction decode and issue. It takes one decoded scalar operation that may carry per-operand vector tags. It expands that operation into a run of element operations. Each element operation keeps the unchanged scalar opcode. The register numbers of the tagged operands step up by the element index, and the registers live in an enlarged scalar register file of 128 entries. No vector registers and no vector opcodes are involved.

While the run is in progress the stage holds the program counter. Elements leave strictly in ascending order, one per issue handshake, so dependencies behave as in an unrolled scalar sequence. The element count comes from a separately programmed vector length, and an optional predicate mask suppresses individual elements. A done strobe tells decode that the program counter may advance. An error strobe reports a stepped register number that would run past entry 127.

The control is a four-state machine:
- Idle: waiting, ready for an op.
- Loop: issuing or skipping one element per cycle, PC held.
- Finish: done strobe for one cycle.
- Fault: error strobe for one cycle.

Its transitions are:
- Idle to Loop: accept with a nonzero count.
- Idle to Finish: accept with a zero count.
- Loop to Loop: element consumed, not last.
- Loop to Finish: last element consumed.
- Loop to Fault: live element overflows.
- Finish to Idle and Fault to Idle: unconditional.

Top module: `vec_issue_seq`

## Requirements
- R1: After reset and between runs, `in_ready` is 1 and `out_valid`, `pc_hold`, `done` and `err` are 0. An op is accepted on a clock edge where `in_valid` and `in_ready` are both 1. `in_ready` stays 0 from the cycle after acceptance until the run has ended.
- R2: Every element operation presents the opcode captured at acceptance, unchanged.
- R3: For element i, an operand whose tag is 1 presents its captured register number plus i. An operand whose tag is 0 presents its captured number for every element. The RT tag is `in_vec_rt`, the RA tag is `in_vec_ra` and the RB tag is `in_vec_rb`.
- R4: Elements are presented in strictly ascending index order, one per accepted handshake (`out_valid` and `out_ready` both 1 at an edge). `out_elem` carries the index.
- R5: `pc_hold` is 1 whenever an element is presented. `done` is a one-cycle pulse, and it rises in the cycle after the handshake of element count-1.
- R6: A tagged op (at least one tag set) runs for `vl` elements, clamped to MAXVL. An untagged op issues exactly one element, whatever the values of `vl`, `pred_en` and `pred_mask`.
- R7: A tagged op with `vl` = 0 issues nothing and raises `done` in the cycle right after acceptance.
- R8: With `pred_en` = 1 on a tagged op, bit i of `pred_mask` (captured at acceptance) enables element i. A disabled element is never presented and uses one cycle of the loop.
- R9: While `out_valid` is 1 and `out_ready` is 0, the next cycle presents the same element with the same fields.
- R10: If an enabled element would give a tagged operand a register number above 127, that element is not presented. `err` pulses for one cycle, and the run ends without `done`. Enabled elements before it issue normally. A disabled element never faults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| in_valid | input | 1 | decoded op present |
| in_ready | output | 1 | stage idle, op can be taken |
| in_opcode | input | OP_W | scalar opcode of the op |
| in_rt | input | 7 | destination register number |
| in_ra | input | 7 | first source register number |
| in_rb | input | 7 | second source register number |
| in_vec_rt | input | 1 | RT steps per element |
| in_vec_ra | input | 1 | RA steps per element |
| in_vec_rb | input | 1 | RB steps per element |
| vl | input | VL_W | current vector length |
| pred_en | input | 1 | apply predicate mask |
| pred_mask | input | MAXVL | per-element enable, bit i for element i |
| out_valid | output | 1 | element op presented |
| out_ready | input | 1 | issue can take the element op |
| out_opcode | output | OP_W | opcode of element op |
| out_rt | output | 7 | stepped destination |
| out_ra | output | 7 | stepped first source |
| out_rb | output | 7 | stepped second source |
| out_elem | output | clog2(MAXVL) | element index |
| pc_hold | output | 1 | program counter must not advance |
| done | output | 1 | run complete, PC may advance |
| err | output | 1 | register stepping overflow, run abandoned |

## Verification
The assertions take for granted only that `rst_n` starts low. They also assume that `vl`, `pred_en`, `pred_mask` and the op fields matter only on the accepting edge. Everything after that edge is checked against captured state, and `out_ready` is allowed to toggle freely.

The stimulus keeps to this rule. It holds the op inputs for exactly one accepting cycle and then changes them freely. It drives `out_ready` with several stall patterns, so that the handshake and stall properties are exercised. The bench uses MAXVL = 8 and sweeps every tag combination against vector lengths 0 to 10, which reaches the clamp. It then walks predicate masks and register bases near 127.

// File: rtl/vseq_pkg.sv
package vseq_pkg;

    localparam int REG_W   = 7;
    localparam int NUM_OPS = 3;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOOP,
        ST_FINISH,
        ST_FAULT
    } seq_state_e;

endpackage

// File: rtl/vseq_regstep.sv
module vseq_regstep #(
    parameter int REG_W = 7,
    parameter int IDX_W = 6
) (
    input  logic [REG_W-1:0] base,
    input  logic             tag,
    input  logic [IDX_W-1:0] idx,
    output logic [REG_W-1:0] reg_num,
    output logic             over
);
    localparam int SUM_W = REG_W + IDX_W + 1;

    logic [SUM_W-1:0] sum;

    always_comb begin
        sum     = SUM_W'(base) + (tag ? SUM_W'(idx) : '0);
        reg_num = sum[REG_W-1:0];
        over    = |sum[SUM_W-1:REG_W];
    end

endmodule

// File: rtl/vseq_ctrl.sv
module vseq_ctrl
    import vseq_pkg::*;
#(
    parameter int MAXVL = 64,
    parameter int VL_W  = 8,
    parameter int IDX_W = 6,
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             vec_op,
    input  logic [VL_W-1:0]  vl,
    input  logic             pred_en,
    input  logic [MAXVL-1:0] pred_mask,
    input  logic             out_ready,
    input  logic             any_over,
    output logic             in_ready,
    output logic             accept,
    output logic [IDX_W-1:0] idx,
    output logic             out_valid,
    output logic             pc_hold,
    output logic             done,
    output logic             err
);
    seq_state_e       state_q, state_d;
    logic [IDX_W-1:0] idx_q, idx_d;
    logic [CNT_W-1:0] cnt_q, cnt_d, cnt_new;
    logic [MAXVL-1:0] mask_q, mask_d;
    logic             pred_q, pred_d;
    logic             live, last, consume;

    // element count for a newly accepted op
    always_comb begin
        if (!vec_op)
            cnt_new = CNT_W'(1);
        else if (vl > VL_W'(MAXVL))
            cnt_new = CNT_W'(MAXVL);
        else
            cnt_new = CNT_W'(vl);
    end

    assign live    = !pred_q || mask_q[idx_q];
    assign last    = (CNT_W'(idx_q) + CNT_W'(1)) == cnt_q;
    assign accept  = (state_q == ST_IDLE) && in_valid;
    assign consume = (state_q == ST_LOOP) && !(live && any_over) && (!live || out_ready);

    // next state and captured loop context
    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        cnt_d   = cnt_q;
        mask_d  = mask_q;
        pred_d  = pred_q;
        unique case (state_q)
            ST_IDLE: begin
                if (in_valid) begin
                    idx_d   = '0;
                    cnt_d   = cnt_new;
                    mask_d  = pred_mask;
                    pred_d  = pred_en && vec_op;
                    state_d = (cnt_new == '0) ? ST_FINISH : ST_LOOP;
                end
            end
            ST_LOOP: begin
                if (live && any_over) begin
                    state_d = ST_FAULT;
                end else if (consume) begin
                    if (last)
                        state_d = ST_FINISH;
                    else
                        idx_d = idx_q + IDX_W'(1);
                end
            end
            ST_FINISH: state_d = ST_IDLE;
            ST_FAULT:  state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            cnt_q   <= '0;
            mask_q  <= '0;
            pred_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
            cnt_q   <= cnt_d;
            mask_q  <= mask_d;
            pred_q  <= pred_d;
        end
    end

    // outputs
    always_comb begin
        in_ready  = 1'b0;
        out_valid = 1'b0;
        pc_hold   = 1'b0;
        done      = 1'b0;
        err       = 1'b0;
        unique case (state_q)
            ST_IDLE:   in_ready = 1'b1;
            ST_LOOP: begin
                pc_hold   = 1'b1;
                out_valid = live && !any_over;
            end
            ST_FINISH: done = 1'b1;
            ST_FAULT:  err  = 1'b1;
            default: ;
        endcase
    end

    assign idx = idx_q;

    assert_issue_holds_pc_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> pc_hold);
    assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && in_ready));
    assert_stall_keeps_elem_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(idx_q)));
    assert_ascending_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready) |=> (!out_valid || (idx_q > $past(idx_q))));
    assert_fault_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (!out_valid && !done && !pc_hold));
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> (!pc_hold && !out_valid && !done));

endmodule

// File: rtl/vec_issue_seq.sv
module vec_issue_seq
    import vseq_pkg::*;
#(
    parameter int MAXVL = 64,
    parameter int VL_W  = 8,
    parameter int OP_W  = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_valid,
    output logic                       in_ready,
    input  logic [OP_W-1:0]            in_opcode,
    input  logic [6:0]                 in_rt,
    input  logic [6:0]                 in_ra,
    input  logic [6:0]                 in_rb,
    input  logic                       in_vec_rt,
    input  logic                       in_vec_ra,
    input  logic                       in_vec_rb,
    input  logic [VL_W-1:0]            vl,
    input  logic                       pred_en,
    input  logic [MAXVL-1:0]           pred_mask,
    output logic                       out_valid,
    input  logic                       out_ready,
    output logic [OP_W-1:0]            out_opcode,
    output logic [6:0]                 out_rt,
    output logic [6:0]                 out_ra,
    output logic [6:0]                 out_rb,
    output logic [$clog2(MAXVL)-1:0]   out_elem,
    output logic                       pc_hold,
    output logic                       done,
    output logic                       err
);
    localparam int IDX_W = $clog2(MAXVL);
    localparam int CNT_W = $clog2(MAXVL + 1);

    logic                               accept;
    logic [IDX_W-1:0]                   idx;
    logic [OP_W-1:0]                    op_q;
    logic [NUM_OPS-1:0][REG_W-1:0]      base_in, base_q, step_reg;
    logic [NUM_OPS-1:0]                 tag_in, tag_q, over_v;
    logic                               vec_op;

    assign base_in = {in_rb, in_ra, in_rt};
    assign tag_in  = {in_vec_rb, in_vec_ra, in_vec_rt};
    assign vec_op  = |tag_in;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q   <= '0;
            base_q <= '0;
            tag_q  <= '0;
        end else if (accept) begin
            op_q   <= in_opcode;
            base_q <= base_in;
            tag_q  <= tag_in;
        end
    end

    for (genvar g = 0; g < NUM_OPS; g++) begin : g_step
        vseq_regstep #(.REG_W(REG_W), .IDX_W(IDX_W)) u_step (
            .base    (base_q[g]),
            .tag     (tag_q[g]),
            .idx     (idx),
            .reg_num (step_reg[g]),
            .over    (over_v[g])
        );
    end

    vseq_ctrl #(.MAXVL(MAXVL), .VL_W(VL_W), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .vec_op    (vec_op),
        .vl        (vl),
        .pred_en   (pred_en),
        .pred_mask (pred_mask),
        .out_ready (out_ready),
        .any_over  (|over_v),
        .in_ready  (in_ready),
        .accept    (accept),
        .idx       (idx),
        .out_valid (out_valid),
        .pc_hold   (pc_hold),
        .done      (done),
        .err       (err)
    );

    assign out_opcode = op_q;
    assign out_rt     = step_reg[0];
    assign out_ra     = step_reg[1];
    assign out_rb     = step_reg[2];
    assign out_elem   = idx;

    assert_stall_fields_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> ($stable(out_rt) && $stable(out_ra) &&
                                       $stable(out_rb) && $stable(out_opcode)));
    assert_opcode_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(out_valid)) |-> $stable(out_opcode));

endmodule

// File: tb/vec_issue_seq_test.sv
`timescale 1ns/1ps
module vec_issue_seq_test;
    localparam int MAXVL = 8;
    localparam int VL_W  = 8;
    localparam int OP_W  = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic in_ready;
    logic [OP_W-1:0] in_opcode = '0;
    logic [6:0] in_rt = '0, in_ra = '0, in_rb = '0;
    logic in_vec_rt = 1'b0, in_vec_ra = 1'b0, in_vec_rb = 1'b0;
    logic [VL_W-1:0] vl = '0;
    logic pred_en = 1'b0;
    logic [MAXVL-1:0] pred_mask = '0;
    logic out_valid;
    logic out_ready = 1'b1;
    logic [OP_W-1:0] out_opcode;
    logic [6:0] out_rt, out_ra, out_rb;
    logic [2:0] out_elem;
    logic pc_hold, done, err;

    int checks = 0;
    int errors = 0;
    bit ended = 0;
    int op_seq = 0;

    always #2 clk = ~clk;

    vec_issue_seq #(.MAXVL(MAXVL), .VL_W(VL_W), .OP_W(OP_W)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_opcode(in_opcode), .in_rt(in_rt), .in_ra(in_ra), .in_rb(in_rb),
        .in_vec_rt(in_vec_rt), .in_vec_ra(in_vec_ra), .in_vec_rb(in_vec_rb),
        .vl(vl), .pred_en(pred_en), .pred_mask(pred_mask),
        .out_valid(out_valid), .out_ready(out_ready), .out_opcode(out_opcode),
        .out_rt(out_rt), .out_ra(out_ra), .out_rb(out_rb), .out_elem(out_elem),
        .pc_hold(pc_hold), .done(done), .err(err)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // tg bits: [2]=RT, [1]=RA, [0]=RB
    task automatic run_op(input int rt, input int ra, input int rb, input bit [2:0] tg,
                          input int vlv, input bit pe, input bit [7:0] mk, input int stall);
        int  cnt, exp_n, got, cyc;
        int  exp_idx [8];
        bit  vec, pred, exp_err, finished, last_acc, prev_stall;
        int  prev_elem, prev_rt, prev_ra, prev_rb;
        bit [OP_W-1:0] opc;
        vec  = |tg;
        cnt  = vec ? ((vlv > MAXVL) ? MAXVL : vlv) : 1;
        pred = pe && vec;
        exp_n = 0; exp_err = 0;
        for (int j = 0; j < cnt; j++) begin
            if (!pred || mk[j]) begin
                if ((tg[2] && rt + j > 127) || (tg[1] && ra + j > 127) || (tg[0] && rb + j > 127)) begin
                    exp_err = 1;
                    break;
                end
                exp_idx[exp_n] = j;
                exp_n++;
            end
        end
        op_seq++;
        opc = 32'hA500_0000 + 32'(op_seq);
        @(negedge clk);
        chk(in_ready === 1'b1, "R1", "in_ready idle", in_ready, 1);
        in_opcode = opc; in_rt = 7'(rt); in_ra = 7'(ra); in_rb = 7'(rb);
        in_vec_rt = tg[2]; in_vec_ra = tg[1]; in_vec_rb = tg[0];
        vl = VL_W'(vlv); pred_en = pe; pred_mask = mk; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        vl = 8'hFF; pred_mask = ~mk; in_opcode = ~opc; in_rt = ~in_rt;
        got = 0; cyc = 0; finished = 0; last_acc = 0; prev_stall = 0;
        prev_elem = 0; prev_rt = 0; prev_ra = 0; prev_rb = 0;
        while (!finished && cyc < 200) begin
            case (stall)
                0: out_ready = 1'b1;
                1: out_ready = (cyc % 2) == 1;
                default: out_ready = (cyc % 3) != 0;
            endcase
            #0;
            if (prev_stall) begin
                chk(out_valid === 1'b1 && int'(out_elem) == prev_elem, "R9", "stall elem",
                    out_elem, prev_elem);
                chk(int'(out_rt) == prev_rt && int'(out_ra) == prev_ra && int'(out_rb) == prev_rb,
                    "R9", "stall regs", out_rt, prev_rt);
            end
            if (!done && !err)
                chk(in_ready === 1'b0, "R1", "in_ready busy", in_ready, 0);
            if (out_valid) begin
                int e;
                e = (got < exp_n) ? exp_idx[got] : -1;
                chk(got < exp_n, "R6", "extra element", got, exp_n);
                chk(pc_hold === 1'b1, "R5", "pc_hold during issue", pc_hold, 1);
                chk(int'(out_elem) == e, "R4", "element index", out_elem, e);
                chk(out_opcode == opc, "R2", "opcode", out_opcode, opc);
                chk(int'(out_rt) == (tg[2] ? rt + e : rt), "R3", "rt", out_rt, tg[2] ? rt + e : rt);
                chk(int'(out_ra) == (tg[1] ? ra + e : ra), "R3", "ra", out_ra, tg[1] ? ra + e : ra);
                chk(int'(out_rb) == (tg[0] ? rb + e : rb), "R3", "rb", out_rb, tg[0] ? rb + e : rb);
                if (pred && e >= 0)
                    chk(mk[e] == 1'b1, "R8", "masked element issued", e, -1);
            end
            if (done) begin
                chk(!exp_err && got == exp_n, "R6", "done count", got, exp_n);
                if (vec && cnt == 0)
                    chk(cyc == 0, "R7", "done cycle for zero length", cyc, 0);
                if (exp_n > 0 && exp_idx[exp_n-1] == cnt - 1)
                    chk(last_acc, "R5", "done follows last handshake", last_acc, 1);
                finished = 1;
            end
            if (err) begin
                chk(exp_err && got == exp_n, "R10", "fault after elements", got, exp_n);
                finished = 1;
            end
            last_acc   = out_valid && out_ready && (int'(out_elem) == cnt - 1);
            if (out_valid && out_ready) got++;
            prev_stall = out_valid && !out_ready;
            prev_elem = out_elem; prev_rt = out_rt; prev_ra = out_ra; prev_rb = out_rb;
            @(negedge clk);
            cyc++;
            if (finished)
                chk(done === 1'b0 && err === 1'b0, "R5", "strobe width", done | err, 0);
        end
        if (!finished)
            chk(1'b0, exp_err ? "R10" : "R5", "run never ended", cyc, 0);
        out_ready = 1'b1;
    endtask

    initial begin
        #600000;
        if (!ended) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(in_ready === 1'b1, "R1", "reset in_ready", in_ready, 1);
        chk(out_valid === 1'b0 && pc_hold === 1'b0, "R1", "reset quiet", out_valid, 0);
        chk(done === 1'b0 && err === 1'b0, "R1", "reset strobes", done | err, 0);

        // every tag combination against lengths 0..10 (clamp at 8), three stall patterns
        for (int v = 0; v <= 10; v++)
            for (int t = 0; t < 8; t++)
                run_op(10 + t, 40, 90 - v, 3'(t), v, 1'b0, 8'h00, (v + t) % 3);

        // R8 predicate sweep on a tagged op
        for (int m = 0; m < 256; m += 17)
            run_op(3, 60, 7, 3'b101, 8, 1'b1, 8'(m), m % 3);
        run_op(3, 60, 7, 3'b111, 8, 1'b1, 8'h80, 1);
        run_op(3, 60, 7, 3'b010, 5, 1'b1, 8'h01, 2);
        run_op(3, 60, 7, 3'b001, 8, 1'b1, 8'hFF, 0);

        // R6 untagged op ignores length and mask
        run_op(5, 6, 7, 3'b000, 7, 1'b1, 8'h00, 0);
        run_op(127, 127, 127, 3'b000, 0, 1'b0, 8'h00, 1);

        // R10 overflow corners
        run_op(125, 1, 2, 3'b100, 6, 1'b0, 8'h00, 0);
        run_op(1, 2, 127, 3'b001, 1, 1'b0, 8'h00, 1);
        run_op(1, 2, 127, 3'b001, 2, 1'b0, 8'h00, 2);
        run_op(126, 0, 0, 3'b100, 4, 1'b1, 8'h03, 0);
        run_op(126, 0, 0, 3'b100, 4, 1'b1, 8'h05, 1);
        run_op(0, 127, 0, 3'b101, 8, 1'b0, 8'h00, 0);

        ended = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule